// File: doc/BRIEF.md
# Serial Transmitter with Empty and Complete Flags

This block sends bytes on a single serial line using one start bit, eight data bits (least significant first) and one stop bit. Each bit lasts sixteen pulses of an externally supplied baud tick. A one-byte holding register sits in front of the shift register, so software can load the next byte while the current one is still going out.

The processor uses a small register bus with three registers. The status register is read-only. The control register holds two interrupt enables and two write-one request bits: one queues a break (line held low) and one queues a preamble (line held high). The data register receives the byte to send.

The two status flags are holding-register-empty and transmit-complete. Software clears them by reading the status register and then writing the data register. Transmit-complete also drops by itself whenever any frame is queued. Each flag drives its own interrupt request, gated by its own enable.

Top module: `uart_tx_stat`

## Requirements
- R1: After reset the status register reads 0xC0: bit 7 is holding-empty = 1, bit 6 is transmit-complete = 1, and bits 5:0 are 0. The serial line is 1 and both interrupt requests are 0.
- R2: A write to the status register (address 0) changes neither flag. The next status read returns the same value as before the write.
- R3: A data write (address 2) is accepted only when it is armed. A status read that sees holding-empty = 1 arms it. A status write between that read and the data write cancels the arm. An unarmed data write is ignored: no flag changes and no frame is sent.
- R4: An accepted byte clears holding-empty. Holding-empty returns to 1 when the shifter takes the byte. A second byte may wait in the holding register while the first byte shifts out.
- R5: A data frame is one start bit at 0, eight data bits sent least significant first, and one stop bit at 1. Each bit lasts 16 baud ticks.
- R6: Writing 1 to control bit 1 (address 1) queues a break frame: the line stays at 0 for ten bit times.
- R7: Writing 1 to control bit 0 queues a preamble frame: the line stays at 1 for ten bit times, and transmit-complete reads 0 throughout.
- R8: Transmit-complete is 1 only while holding-empty is 1 and no frame is active or pending. While transmit-complete is 1, the line is 1.
- R9: Transmit-complete falls automatically when a data, break or preamble frame is queued.
- R10: irq_tx equals holding-empty AND control bit 7. irq_tc equals transmit-complete AND control bit 6. Control reads return the two enables in bits 7:6.
- R11: Pending frames start in this order: break first, then preamble, then data. A pending frame starts in the same cycle the previous frame ends, so transmit-complete does not pulse between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 status, 1 control, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| txd | output | 1 | Serial line |
| irq_tx | output | 1 | Holding-register-empty interrupt request |
| irq_tc | output | 1 | Transmit-complete interrupt request |

## Verification
Two events can fall in the same clock cycle: the end of one frame and the start of a pending frame. The bench provokes this by queueing a break while a preamble is still on the line, and by requesting break and preamble together. It counts every rising edge of irq_tc and requires exactly one, after the last frame has ended. A second case is the shifter taking a byte from the holding register while a new byte is being armed. The bench checks that holding-empty reads 1 and then 0 around the second write, and that the scoreboard receives both bytes in order.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int BUS_W = 8;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // status bit positions
    localparam int ST_EMPTY = 7;
    localparam int ST_DONE  = 6;

    // control bit positions
    localparam int CT_IE_TX = 7;
    localparam int CT_IE_TC = 6;
    localparam int CT_BRK   = 1;
    localparam int CT_PRE   = 0;

    typedef enum logic [1:0] {
        FR_DATA  = 2'd0,
        FR_BREAK = 2'd1,
        FR_PRE   = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              start,
    input  frame_kind_e       kind,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int TICK_W  = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVS - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic               txd;
        logic [FRAME_W-1:0] shreg;
        logic [TICK_W-1:0]  tick;
        logic [BIT_W-1:0]   bitn;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [FRAME_W-1:0] pattern_d;

    always_comb begin
        case (kind)
            FR_DATA:  pattern_d = {1'b1, data, 1'b0};
            FR_BREAK: pattern_d = '0;
            default:  pattern_d = '1;
        endcase
    end

    assign done = sh_q.busy && baud_tick && (sh_q.tick == TICK_LAST)
                  && (sh_q.bitn == BIT_LAST);

    always_comb begin
        sh_d = sh_q;
        if (sh_q.busy && baud_tick) begin
            if (sh_q.tick == TICK_LAST) begin
                sh_d.tick = '0;
                if (sh_q.bitn == BIT_LAST) begin
                    sh_d.busy = 1'b0;
                    sh_d.txd  = 1'b1;
                end else begin
                    sh_d.bitn  = sh_q.bitn + 1'b1;
                    sh_d.shreg = {1'b1, sh_q.shreg[FRAME_W-1:1]};
                    sh_d.txd   = sh_q.shreg[1];
                end
            end else begin
                sh_d.tick = sh_q.tick + 1'b1;
            end
        end
        if (start) begin
            sh_d.busy  = 1'b1;
            sh_d.tick  = '0;
            sh_d.bitn  = '0;
            sh_d.shreg = pattern_d;
            sh_d.txd   = pattern_d[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.busy  <= 1'b0;
            sh_q.txd   <= 1'b1;
            sh_q.shreg <= '1;
            sh_q.tick  <= '0;
            sh_q.bitn  <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd  = sh_q.txd;
    assign busy = sh_q.busy;
endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              sh_busy,
    input  logic              sh_done,
    output logic              sh_start,
    output frame_kind_e       sh_kind,
    output logic [DATA_W-1:0] hold,
    output logic              empty,
    output logic              complete,
    output logic              ie_tx,
    output logic              ie_tc
);
    typedef struct packed {
        logic              empty;
        logic              complete;
        logic              arm_empty;
        logic              arm_done;
        logic              ie_tx;
        logic              ie_tc;
        logic              pend_brk;
        logic              pend_pre;
        logic [DATA_W-1:0] hold;
    } rg_t;

    rg_t rg_d, rg_q;

    logic st_rd, st_wr, dat_wr, ctl_wr, free, busy_next;

    assign st_rd  = bus_sel && !bus_we && (bus_addr == ADDR_STAT);
    assign st_wr  = bus_sel &&  bus_we && (bus_addr == ADDR_STAT);
    assign dat_wr = bus_sel &&  bus_we && (bus_addr == ADDR_DATA);
    assign ctl_wr = bus_sel &&  bus_we && (bus_addr == ADDR_CTRL);

    // shifter can accept a frame when idle or finishing this cycle
    assign free     = !sh_busy || sh_done;
    assign sh_start = free && (rg_q.pend_brk || rg_q.pend_pre || !rg_q.empty);

    always_comb begin
        if (rg_q.pend_brk)      sh_kind = FR_BREAK;
        else if (rg_q.pend_pre) sh_kind = FR_PRE;
        else                    sh_kind = FR_DATA;
    end

    assign busy_next = sh_start || (sh_busy && !sh_done);

    always_comb begin
        rg_d = rg_q;

        if (sh_start) begin
            case (sh_kind)
                FR_BREAK: rg_d.pend_brk = 1'b0;
                FR_PRE:   rg_d.pend_pre = 1'b0;
                default:  rg_d.empty    = 1'b1;
            endcase
        end

        if (st_rd) begin
            rg_d.arm_empty = rg_q.empty;
            rg_d.arm_done  = rg_q.complete;
        end else if (st_wr) begin
            rg_d.arm_empty = 1'b0;
            rg_d.arm_done  = 1'b0;
        end

        if (dat_wr) begin
            if (rg_q.arm_empty) begin
                rg_d.hold  = bus_wdata[DATA_W-1:0];
                rg_d.empty = 1'b0;
            end
            rg_d.arm_empty = 1'b0;
            rg_d.arm_done  = 1'b0;
        end

        if (ctl_wr) begin
            rg_d.ie_tx = bus_wdata[CT_IE_TX];
            rg_d.ie_tc = bus_wdata[CT_IE_TC];
            if (bus_wdata[CT_BRK]) rg_d.pend_brk = 1'b1;
            if (bus_wdata[CT_PRE]) rg_d.pend_pre = 1'b1;
        end

        rg_d.complete = rg_d.empty && !busy_next && !rg_d.pend_brk
                        && !rg_d.pend_pre && !(dat_wr && rg_q.arm_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.empty     <= 1'b1;
            rg_q.complete  <= 1'b1;
            rg_q.arm_empty <= 1'b0;
            rg_q.arm_done  <= 1'b0;
            rg_q.ie_tx     <= 1'b0;
            rg_q.ie_tc     <= 1'b0;
            rg_q.pend_brk  <= 1'b0;
            rg_q.pend_pre  <= 1'b0;
            rg_q.hold      <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_STAT: begin
                bus_rdata[ST_EMPTY] = rg_q.empty;
                bus_rdata[ST_DONE]  = rg_q.complete;
            end
            ADDR_CTRL: begin
                bus_rdata[CT_IE_TX] = rg_q.ie_tx;
                bus_rdata[CT_IE_TC] = rg_q.ie_tc;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign hold     = rg_q.hold;
    assign empty    = rg_q.empty;
    assign complete = rg_q.complete;
    assign ie_tx    = rg_q.ie_tx;
    assign ie_tc    = rg_q.ie_tc;
endmodule

// File: rtl/uart_tx_stat.sv
module uart_tx_stat
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             txd,
    output logic             irq_tx,
    output logic             irq_tc
);
    logic              sh_busy, sh_done, sh_start;
    frame_kind_e       sh_kind;
    logic [DATA_W-1:0] hold_w;
    logic              empty_w, complete_w, ie_tx_w, ie_tc_w;

    uart_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sh_busy   (sh_busy),
        .sh_done   (sh_done),
        .sh_start  (sh_start),
        .sh_kind   (sh_kind),
        .hold      (hold_w),
        .empty     (empty_w),
        .complete  (complete_w),
        .ie_tx     (ie_tx_w),
        .ie_tc     (ie_tc_w)
    );

    uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .start     (sh_start),
        .kind      (sh_kind),
        .data      (hold_w),
        .txd       (txd),
        .busy      (sh_busy),
        .done      (sh_done)
    );

    assign irq_tx = empty_w && ie_tx_w;
    assign irq_tc = complete_w && ie_tc_w;
endmodule

// File: rtl/uart_tx_stat_chk.sv
module uart_tx_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic       txd,
    input logic       empty,
    input logic       complete
);
    // R1
    rst_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && complete));

    // R8
    done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |-> empty);

    // R8
    done_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |-> txd);

    // R3
    empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty) |-> $past(bus_sel && bus_we && bus_addr == 2'd2));

    // R9
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(complete) |-> $past(bus_sel && bus_we
                                  && (bus_addr == 2'd2 || bus_addr == 2'd1)));

    // R2
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 2'd0) |=> !$fell(empty));
endmodule

bind uart_tx_stat uart_tx_stat_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .txd      (txd),
    .empty    (empty_w),
    .complete (complete_w)
);

// File: tb/sim_uart_tx_stat.sv
`timescale 1ns/1ps
module sim_uart_tx_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       txd, irq_tx, irq_tc;

    int checks = 0;
    int failures = 0;
    int tc_rises = 0;
    bit finished = 0;

    typedef struct packed { logic is_brk; logic [7:0] d; } item_t;
    item_t expq[$];

    uart_tx_stat u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .irq_tx(irq_tx), .irq_tc(irq_tc)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = rst_n ? ~baud_tick : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // driver: armed send, expectation pushed to scoreboard
    task automatic send_byte(input logic [7:0] v);
        logic [7:0] s;
        bus_rd(2'd0, s);
        bus_wr(2'd2, v);
        expq.push_back({1'b0, v});
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (baud_tick) c++;
        end
        #1;
    endtask

    // monitor: decode frames from the line, compare against scoreboard
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd) begin
                logic [9:0] bits;
                item_t got, exp;
                wait_ticks(8);
                bits[0] = txd;
                for (int i = 1; i < 10; i++) begin
                    wait_ticks(16);
                    bits[i] = txd;
                end
                got.is_brk = (bits == 10'd0);
                got.d = bits[8:1];
                if (expq.size() == 0) begin
                    check(1'b0, "R5 unexpected frame", int'(got), 0);
                end else begin
                    exp = expq.pop_front();
                    if (exp.is_brk)
                        check(got.is_brk, "R6 break frame", int'(bits), 0);
                    else begin
                        check(got.d == exp.d, "R5 data bits", got.d, exp.d);
                        check(bits[9] == 1'b1 && bits[0] == 1'b0, "R5 start/stop",
                              {bits[9], bits[0]}, 2'b10);
                    end
                end
                while (!txd) @(negedge clk);
            end
            prev = txd;
        end
    end

    initial begin
        logic p = 1'b0;
        forever begin
            @(negedge clk);
            if (irq_tc && !p) tc_rises++;
            p = irq_tc;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check(txd == 1'b1 && irq_tx == 1'b0 && irq_tc == 1'b0, "R1 outputs",
              {txd, irq_tx, irq_tc}, 3'b100);
        bus_rd(2'd0, v);
        check(v == 8'hC0, "R1 status", v, 8'hC0);

        // R2 status write ignored (also cancels the arm from the read above)
        bus_wr(2'd0, 8'h00);
        bus_rd(2'd0, v);
        check(v == 8'hC0, "R2 status after write", v, 8'hC0);

        // R3 cancelled arm: read, status write, data write -> ignored
        bus_wr(2'd0, 8'hFF);
        bus_wr(2'd2, 8'h55);
        repeat (30) @(negedge clk);
        check(txd == 1'b1, "R3 line idle after unarmed write", txd, 1);
        bus_rd(2'd0, v);
        check(v == 8'hC0, "R3 flags unchanged", v, 8'hC0);
        bus_wr(2'd0, 8'h00);

        // R10 enables
        bus_wr(2'd1, 8'hC0);
        bus_rd(2'd1, v);
        check(v == 8'hC0, "R10 control readback", v, 8'hC0);
        @(negedge clk);
        check(irq_tx && irq_tc, "R10 both irqs", {irq_tx, irq_tc}, 2'b11);

        // R4 R5 R9 back-to-back bytes
        send_byte(8'h3C);
        check(irq_tc == 1'b0, "R9 tc falls on queue", irq_tc, 0);
        repeat (3) @(negedge clk);
        bus_rd(2'd0, v);
        check(v == 8'h80, "R4 empty after take", v, 8'h80);
        bus_wr(2'd2, 8'h81);
        expq.push_back({1'b0, 8'h81});
        repeat (3) @(negedge clk);
        bus_rd(2'd0, v);
        check(v == 8'h00, "R4 holding full", v, 8'h00);
        check(irq_tx == 1'b0, "R10 irq_tx low when full", irq_tx, 0);
        repeat (340) @(negedge clk);
        bus_rd(2'd0, v);
        check(v == 8'h80 && irq_tx, "R4 second byte taken", v, 8'h80);
        repeat (340) @(negedge clk);
        bus_rd(2'd0, v);
        check(v == 8'hC0 && irq_tc, "R8 complete after both", v, 8'hC0);
        bus_wr(2'd0, 8'h00);

        // R7 preamble
        bus_wr(2'd1, 8'h01);
        repeat (100) @(negedge clk);
        check(txd == 1'b1, "R7 preamble line high", txd, 1);
        bus_rd(2'd0, v);
        check(v == 8'h80, "R7 complete low in preamble", v, 8'h80);
        repeat (260) @(negedge clk);
        bus_rd(2'd0, v);
        check(v == 8'hC0, "R7 complete after preamble", v, 8'hC0);
        bus_wr(2'd0, 8'h00);

        // R11 break before preamble when both requested
        expq.push_back({1'b1, 8'h00});
        bus_wr(2'd1, 8'h03);
        repeat (100) @(negedge clk);
        check(txd == 1'b0, "R11 break first", txd, 0);
        repeat (320) @(negedge clk);
        check(txd == 1'b1, "R11 preamble second", txd, 1);
        bus_rd(2'd0, v);
        check(v == 8'h80, "R11 complete low during preamble", v, 8'h80);
        repeat (300) @(negedge clk);
        bus_wr(2'd0, 8'h00);

        // R11 R6 preamble then break queued mid-frame: no tc pulse between
        bus_wr(2'd1, 8'hC1);
        tc_rises = 0;
        repeat (100) @(negedge clk);
        bus_wr(2'd1, 8'hC2);
        expq.push_back({1'b1, 8'h00});
        repeat (700) @(negedge clk);
        check(tc_rises == 1, "R11 single tc rise", tc_rises, 1);
        bus_rd(2'd0, v);
        check(v == 8'hC0 && txd, "R6 idle after break", v, 8'hC0);

        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R5 scoreboard drained", expq.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule